// File: doc/BRIEF.md
# Ethernet Status LED Driver

This block turns the status of a 10/100 Ethernet transceiver into three active-low LED drives. The three LEDs show link, traffic and speed. The link and speed LEDs follow their status inputs, with one register between each input and its pin.

The traffic LED is driven by per-packet strobes, one for the transmit direction and one for the receive direction. Each strobe carries two tags: one marks a broadcast frame, the other marks a frame whose destination matched the station's own address. A wake-on-LAN mode flag and a filter bit decide which strobes count as traffic.

A qualifying strobe lights the traffic LED and keeps it lit for a stretch window. If traffic keeps arriving through the whole window, the LED is forced dark for a fixed interval and then lights again. Under steady load the LED therefore blinks, and heavier traffic makes the blinking more regular. While the link is down, the traffic and speed LEDs stay dark and the stretch logic is cleared.

Top module: `phy_led_ctrl`

## Requirements
- R1: All three outputs are active low (0 = lit). While `rst` is high, every output is 1 and the stretch logic returns to idle.
- R2: `led_link_n` equals the inverse of `link_up` as sampled at the previous rising clock edge, at either speed.
- R3: With the link up, `led_spd_n` is 0 when `speed_100` was 1 at the previous edge and 1 when it was 0.
- R4: While `link_up` is 0, `led_spd_n` and `led_act_n` are 1. Strobes seen during that time are discarded, and the stretch logic is idle once the link returns.
- R5: With `wol_mode` at 0, every `tx_evt` or `rx_evt` strobe qualifies, whatever its tags.
- R6: With `wol_mode` at 1 and `wol_match_only` at 0, a strobe qualifies if it carries the broadcast tag or the address-match tag. A strobe with neither tag is ignored.
- R7: With `wol_mode` at 1 and `wol_match_only` at 1, only strobes carrying the address-match tag qualify. Broadcast-only strobes are ignored.
- R8: When the stretch logic is idle and a qualifying strobe arrives at edge k, `led_act_n` goes to 0 after edge k+1. Each further qualifying strobe restarts a window of `STRETCH_CYCLES` cycles. The LED goes dark once a whole window passes with no qualifying strobe.
- R9: After `STRETCH_CYCLES` consecutive lit cycles with traffic still pending, the LED is dark for exactly `OFF_CYCLES` cycles. It relights if a qualifying strobe arrived during that dark interval; otherwise it stays dark.
- R10: With no qualifying strobe, `led_act_n` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link established |
| speed_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| tx_evt | input | 1 | One-cycle strobe per transmitted packet |
| tx_bcast | input | 1 | Transmit packet is broadcast |
| tx_match | input | 1 | Transmit packet matched the station address |
| rx_evt | input | 1 | One-cycle strobe per received packet |
| rx_bcast | input | 1 | Receive packet is broadcast |
| rx_match | input | 1 | Receive packet matched the station address |
| wol_mode | input | 1 | Wake-on-LAN mode active |
| wol_match_only | input | 1 | In wake-on-LAN mode, count only address-match packets |
| led_link_n | output | 1 | Link LED, active low |
| led_act_n | output | 1 | Traffic LED, active low |
| led_spd_n | output | 1 | Speed LED, active low |

## Verification
The bench targets the following corner cases:
- **Wake-on-LAN filtering.** Untagged and broadcast-only strobes are sent with the filter bit at each value. A swapped or ignored filter bit would light the traffic LED when it should stay dark.
- **Steady traffic.** Strobes are sent back to back so the forced dark interval has to appear at exactly the right cycle and last exactly the right length. An off-by-one counter would shift every later blink.
- **Dark interval outcomes.** The bench covers a strobe that lands inside the dark interval and a dark interval with no strobe. The first must relight the LED; the second must leave it dark.
- **Link loss.** The link is dropped with traffic in flight. A design that kept its stretch state would relight a stale LED when the link returns.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LIT  = 2'd1,
    ACT_DARK = 2'd2
  } act_state_e;
endpackage

// File: rtl/led_evt_qual.sv
module led_evt_qual #(
  parameter int N_DIR = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DIR-1:0] evt,
  input  logic [N_DIR-1:0] bcast,
  input  logic [N_DIR-1:0] match,
  input  logic             wol_mode,
  input  logic             wol_match_only,
  output logic             hit
);
  logic [N_DIR-1:0] qual;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    // A strobe passes when no filter applies, when it matched the station
    // address, or when it is broadcast and broadcasts are allowed.
    assign qual[d] = evt[d] & (~wol_mode | match[d] | (~wol_match_only & bcast[d]));
  end

  assign hit = |qual;

  // R7
  match_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wol_mode && wol_match_only && ((evt & match) == '0)) |-> !hit);

  // R6
  untagged_chk: assert property (@(posedge clk) disable iff (rst)
    (wol_mode && ((evt & (bcast | match)) == '0)) |-> !hit);
endmodule

// File: rtl/led_act_stretch.sv
module led_act_stretch
  import led_pkg::*;
#(
  parameter int STRETCH_CYCLES = 65536,
  parameter int OFF_CYCLES     = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hit,
  output logic lit
);
  localparam int HOLD_W = (STRETCH_CYCLES > 2) ? $clog2(STRETCH_CYCLES) : 1;
  localparam int OFF_W  = (OFF_CYCLES > 2) ? $clog2(OFF_CYCLES) : 1;
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(STRETCH_CYCLES - 1);
  localparam logic [OFF_W-1:0]  OFF_MAX  = OFF_W'(OFF_CYCLES - 1);

  act_state_e        state_q;
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] run_q;
  logic [OFF_W-1:0]  off_q;
  logic              pend_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= ACT_IDLE;
      hold_q  <= '0;
      run_q   <= '0;
      off_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ACT_IDLE: begin
          if (hit) begin
            state_q <= ACT_LIT;
            hold_q  <= HOLD_MAX;
            run_q   <= '0;
          end
        end
        ACT_LIT: begin
          if (!hit && hold_q == '0) begin
            state_q <= ACT_IDLE;
          end else if (run_q == HOLD_MAX) begin
            state_q <= ACT_DARK;
            off_q   <= OFF_MAX;
            pend_q  <= 1'b0;
          end else begin
            hold_q <= hit ? HOLD_MAX : hold_q - 1'b1;
            run_q  <= run_q + 1'b1;
          end
        end
        ACT_DARK: begin
          if (off_q == '0) begin
            if (pend_q || hit) begin
              state_q <= ACT_LIT;
              hold_q  <= HOLD_MAX;
              run_q   <= '0;
            end else begin
              state_q <= ACT_IDLE;
            end
            pend_q <= 1'b0;
          end else begin
            off_q  <= off_q - 1'b1;
            pend_q <= pend_q | hit;
          end
        end
        default: state_q <= ACT_IDLE;
      endcase
    end
  end

  assign lit = (state_q == ACT_LIT);

  // R8
  lit_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lit) |-> ($past(hit) || $past(pend_q)));

  // R4
  clear_dark_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !lit);

  // R9
  dark_from_lit_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (state_q == ACT_DARK && off_q == OFF_MAX) |-> $past(lit));
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl #(
  parameter int STRETCH_CYCLES = 65536,
  parameter int OFF_CYCLES     = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic link_up,
  input  logic speed_100,
  input  logic tx_evt,
  input  logic tx_bcast,
  input  logic tx_match,
  input  logic rx_evt,
  input  logic rx_bcast,
  input  logic rx_match,
  input  logic wol_mode,
  input  logic wol_match_only,
  output logic led_link_n,
  output logic led_act_n,
  output logic led_spd_n
);
  localparam int N_DIR = 2;

  logic hit;
  logic lit;
  logic armed_q;

  led_evt_qual #(.N_DIR(N_DIR)) i_qual (
    .clk            (clk),
    .rst            (rst),
    .evt            ({rx_evt, tx_evt}),
    .bcast          ({rx_bcast, tx_bcast}),
    .match          ({rx_match, tx_match}),
    .wol_mode       (wol_mode),
    .wol_match_only (wol_match_only),
    .hit            (hit)
  );

  led_act_stretch #(
    .STRETCH_CYCLES (STRETCH_CYCLES),
    .OFF_CYCLES     (OFF_CYCLES)
  ) i_stretch (
    .clk (clk),
    .rst (rst),
    .clr (!link_up),
    .hit (hit),
    .lit (lit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led_link_n <= 1'b1;
      led_act_n  <= 1'b1;
      led_spd_n  <= 1'b1;
      armed_q    <= 1'b0;
    end else begin
      led_link_n <= !link_up;
      led_act_n  <= !(link_up && lit);
      led_spd_n  <= !(link_up && speed_100);
      armed_q    <= 1'b1;
    end
  end

  // R2
  link_follow_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (led_link_n == !$past(link_up)));

  // R4
  link_down_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !$past(link_up)) |-> (led_spd_n && led_act_n));

  // R1
  reset_dark_chk: assert property (@(posedge clk)
    $past(rst) |-> (led_link_n && led_act_n && led_spd_n));
endmodule

// File: tb/test_phy_led_ctrl.sv
module test_phy_led_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STRETCH    = 8;
  localparam int OFFLEN     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up = 0, speed_100 = 0;
  logic tx_evt = 0, tx_bcast = 0, tx_match = 0;
  logic rx_evt = 0, rx_bcast = 0, rx_match = 0;
  logic wol_mode = 0, wol_match_only = 0;
  logic led_link_n, led_act_n, led_spd_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_led_ctrl #(.STRETCH_CYCLES(STRETCH), .OFF_CYCLES(OFFLEN)) i_phy_led_ctrl (
    .clk(clk), .rst(rst), .link_up(link_up), .speed_100(speed_100),
    .tx_evt(tx_evt), .tx_bcast(tx_bcast), .tx_match(tx_match),
    .rx_evt(rx_evt), .rx_bcast(rx_bcast), .rx_match(rx_match),
    .wol_mode(wol_mode), .wol_match_only(wol_match_only),
    .led_link_n(led_link_n), .led_act_n(led_act_n), .led_spd_n(led_spd_n)
  );

  // Behavioural reference: mode 0 idle, 1 lit, 2 forced dark.
  int  m_mode = 0, m_quiet = 0, m_lit_len = 0, m_dark_left = 0;
  bit  m_seen = 0;
  bit  e_link = 1, e_act = 1, e_spd = 1;

  function automatic bit counts(bit ev, bit bc, bit ma);
    if (!ev) return 0;
    if (!wol_mode) return 1;
    if (wol_match_only) return ma;
    return bc || ma;
  endfunction

  always @(posedge clk) begin
    bit q;
    cycles++;
    if (rst) begin
      e_link = 1; e_act = 1; e_spd = 1;
      m_mode = 0; m_seen = 0; m_quiet = 0; m_lit_len = 0; m_dark_left = 0;
    end else begin
      e_link = !link_up;
      e_spd  = !(link_up && speed_100);
      e_act  = !(link_up && m_mode == 1);
      q = counts(tx_evt, tx_bcast, tx_match) || counts(rx_evt, rx_bcast, rx_match);
      if (!link_up) begin
        m_mode = 0; m_seen = 0;
      end else if (m_mode == 0) begin
        if (q) begin m_mode = 1; m_quiet = 0; m_lit_len = 1; end
      end else if (m_mode == 1) begin
        if (q) m_quiet = 0; else m_quiet++;
        if (m_quiet >= STRETCH) m_mode = 0;
        else if (m_lit_len == STRETCH) begin
          m_mode = 2; m_dark_left = OFFLEN; m_seen = 0;
        end else m_lit_len++;
      end else begin
        m_seen = m_seen || q;
        m_dark_left--;
        if (m_dark_left == 0) begin
          if (m_seen) begin m_mode = 1; m_quiet = 0; m_lit_len = 1; end
          else m_mode = 0;
          m_seen = 0;
        end
      end
    end
  end

  task automatic check1(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", phase, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      check1("led_link_n", led_link_n, e_link);
      check1("led_act_n", led_act_n, e_act);
      check1("led_spd_n", led_spd_n, e_spd);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(bit is_rx, bit bc, bit ma);
    @(negedge clk);
    if (is_rx) begin rx_evt = 1; rx_bcast = bc; rx_match = ma; end
    else begin tx_evt = 1; tx_bcast = bc; tx_match = ma; end
    @(negedge clk);
    rx_evt = 0; tx_evt = 0; rx_bcast = 0; rx_match = 0; tx_bcast = 0; tx_match = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    phase = "R1";
    idle(4);
    rst = 0;
    phase = "R2";
    link_up = 1; idle(5);
    phase = "R3";
    speed_100 = 1; idle(4); speed_100 = 0; idle(3); speed_100 = 1;
    phase = "R10";
    idle(10);
    phase = "R8";
    strobe(0, 0, 0); idle(20);
    strobe(1, 1, 0); idle(3); strobe(0, 0, 1); idle(20);
    phase = "R9";
    for (int i = 0; i < 40; i++) strobe(i % 2, 0, 0);
    idle(20);
    for (int i = 0; i < 5; i++) strobe(0, 0, 0);
    idle(3); strobe(1, 0, 0); idle(25);
    for (int i = 0; i < 4; i++) strobe(1, 0, 0);
    idle(25);
    phase = "R5";
    strobe(0, 0, 0); idle(20); strobe(1, 1, 1); idle(20);
    phase = "R6";
    wol_mode = 1; wol_match_only = 0;
    strobe(0, 0, 0); strobe(1, 0, 0); idle(12);
    strobe(1, 1, 0); idle(20); strobe(0, 0, 1); idle(20);
    phase = "R7";
    wol_match_only = 1;
    strobe(0, 1, 0); strobe(1, 1, 0); idle(12);
    strobe(1, 0, 1); idle(20); strobe(0, 1, 1); idle(20);
    wol_mode = 0; wol_match_only = 0;
    phase = "R4";
    strobe(0, 0, 0); idle(2);
    link_up = 0;
    for (int i = 0; i < 6; i++) strobe(i % 2, 1, 1);
    idle(4); link_up = 1; idle(20);
    link_up = 0; idle(5); link_up = 1; speed_100 = 0; idle(10);
    phase = "R1";
    strobe(0, 0, 0); idle(1); rst = 1; idle(4); rst = 0; idle(10);
    finish_run();
  end
endmodule